// File: doc/BRIEF.md
# Packed Lane Shift Unit

This block shifts a 64-bit packed operand by a variable count. The operand is split into equal lanes of 16, 32 or 64 bits, and the lane size comes with each operation. Every lane is shifted on its own. A bit that leaves one lane is dropped and never reaches the next lane. The unit supports logical shifts to the left and to the right at all three lane sizes. Arithmetic right shifts are available only at the two narrower lane sizes.

The count arrives already resolved, as a full 64-bit unsigned value, and one count applies to every lane. The result register loads one cycle after a valid strobe, and a registered valid flag marks the new result. The unit sits behind an issue stage that supplies the operand, the count and a 3-bit operation code.

Top module: `pshift_unit`

## Requirements
- R1: Logical left shift fills the vacated low bits with zeros. Code 0 shifts 16-bit lanes, code 1 shifts 32-bit lanes and code 2 shifts the whole 64-bit word.
- R2: Logical right shift fills the vacated high bits with zeros. Code 3 shifts 16-bit lanes, code 4 shifts 32-bit lanes and code 5 shifts the 64-bit word.
- R3: Arithmetic right shift fills the vacated high bits with copies of each lane's original top bit. Code 6 shifts 16-bit lanes and code 7 shifts 32-bit lanes.
- R4: No bit moves from one lane into a neighbouring lane, in either direction.
- R5: For the logical codes (0 to 5), a count equal to or greater than the lane width gives an all-zero lane. All 64 bits of the count are taken into account.
- R6: For the arithmetic codes (6 and 7), a count equal to or greater than the lane width sets every bit of each lane to that lane's sign bit.
- R7: A count of zero returns the operand unchanged, for every operation code.
- R8: The result appears on `out_data` with `out_valid` high exactly one cycle after the cycle in which `in_valid` was high. `out_valid` is low in the cycle after a cycle with `in_valid` low.
- R9: While `in_valid` is low, `out_data` keeps its last value, whatever the other inputs do.
- R10: A synchronous active-high reset clears `out_valid`, even when `in_valid` is high during the reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Operation code (see R1 to R3) |
| in_data | input | 64 | Packed operand |
| in_count | input | 64 | Unsigned shift count, the same for all lanes |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 64 | Registered shifted result |

## Verification
The assertions are checked on every cycle. They cover the valid pipeline, the holding of the result while the strobe is low, the identity result for a zero count, and the saturated outcomes for large counts (zero lanes for the logical codes, sign-filled lanes for the arithmetic codes).

The bench scenarios cover the rest. A reference model computes every bit of every lane for each shift, including shifts that straddle lane edges. The scenarios also check the exact fill pattern at each lane size, counts whose only set bits lie in the upper half of the count, and reset arriving together with a strobe.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

  typedef enum logic [2:0] {
    OP_SLL16 = 3'd0,
    OP_SLL32 = 3'd1,
    OP_SLL64 = 3'd2,
    OP_SRL16 = 3'd3,
    OP_SRL32 = 3'd4,
    OP_SRL64 = 3'd5,
    OP_SRA16 = 3'd6,
    OP_SRA32 = 3'd7
  } shift_op_e;

  // Decoded control: direction, fill type, lane size index (0:16,1:32,2:64)
  typedef struct packed {
    logic       legal;
    logic       left;
    logic       arith;
    logic [1:0] size;
  } shift_ctl_t;

endpackage

// File: rtl/pshift_decode.sv
module pshift_decode
  import pshift_pkg::*;
(
  input  logic [2:0]  op,
  output shift_ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (shift_op_e'(op))
      OP_SLL16: ctl = '{legal: 1'b1, left: 1'b1, arith: 1'b0, size: 2'd0};
      OP_SLL32: ctl = '{legal: 1'b1, left: 1'b1, arith: 1'b0, size: 2'd1};
      OP_SLL64: ctl = '{legal: 1'b1, left: 1'b1, arith: 1'b0, size: 2'd2};
      OP_SRL16: ctl = '{legal: 1'b1, left: 1'b0, arith: 1'b0, size: 2'd0};
      OP_SRL32: ctl = '{legal: 1'b1, left: 1'b0, arith: 1'b0, size: 2'd1};
      OP_SRL64: ctl = '{legal: 1'b1, left: 1'b0, arith: 1'b0, size: 2'd2};
      OP_SRA16: ctl = '{legal: 1'b1, left: 1'b0, arith: 1'b1, size: 2'd0};
      OP_SRA32: ctl = '{legal: 1'b1, left: 1'b0, arith: 1'b1, size: 2'd1};
      default:  ctl = '0;
    endcase
  end

endmodule

// File: rtl/pshift_lane.sv
module pshift_lane #(
  parameter int LW    = 16,
  parameter int CNT_W = 64
) (
  input  logic [LW-1:0]    data,
  input  logic [CNT_W-1:0] count,
  input  logic             left,
  input  logic             arith,
  output logic [LW-1:0]    result
);

  localparam int SH_W = $clog2(LW);

  logic [SH_W-1:0] sh;
  logic            over;
  logic            sign;

  assign sh   = count[SH_W-1:0];
  assign over = |count[CNT_W-1:SH_W];
  assign sign = data[LW-1];

  always_comb begin
    if (over) begin
      result = (arith && !left) ? {LW{sign}} : '0;
    end else if (left) begin
      result = data << sh;
    end else if (arith) begin
      result = LW'($signed(data) >>> sh);
    end else begin
      result = data >> sh;
    end
  end

endmodule

// File: rtl/pshift_size.sv
module pshift_size #(
  parameter int DATA_W = 64,
  parameter int LW     = 16,
  parameter int CNT_W  = 64
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  count,
  input  logic              left,
  input  logic              arith,
  output logic [DATA_W-1:0] result
);

  localparam int NL = DATA_W / LW;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    pshift_lane #(.LW(LW), .CNT_W(CNT_W)) u_lane (
      .data   (data[k*LW +: LW]),
      .count  (count),
      .left   (left),
      .arith  (arith),
      .result (result[k*LW +: LW])
    );
  end

endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
  import pshift_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 64,
  parameter int MIN_LANE  = 16,
  parameter int NUM_SIZES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  shift_ctl_t        ctl;
  logic [DATA_W-1:0] size_res [NUM_SIZES];
  logic [DATA_W-1:0] sel_res;

  pshift_decode u_dec (
    .op  (in_op),
    .ctl (ctl)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int LW = MIN_LANE << g;
    logic [DATA_W-1:0] res;
    pshift_size #(.DATA_W(DATA_W), .LW(LW), .CNT_W(CNT_W)) u_size (
      .data   (in_data),
      .count  (in_count),
      .left   (ctl.left),
      .arith  (ctl.arith),
      .result (res)
    );
    assign size_res[g] = res;
  end

  always_comb begin
    sel_res = '0;
    if (ctl.legal) begin
      for (int s = 0; s < NUM_SIZES; s++) begin
        if (ctl.size == 2'(s)) sel_res = size_res[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_data <= sel_res;
  end

endmodule

// File: rtl/pshift_unit_chk.sv
module pshift_unit_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_data,
  input logic [CNT_W-1:0]  in_count,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_valid) |=> $stable(out_data));

  assert_zero_count_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_count == '0) |=> out_data == $past(in_data));

  assert_sll16_over_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd0 && |in_count[CNT_W-1:4]) |=> out_data == '0);

  assert_srl64_over_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd5 && |in_count[CNT_W-1:6]) |=> out_data == '0);

  assert_sra32_over_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 3'd7 && |in_count[CNT_W-1:5]) |=>
      out_data == {{32{$past(in_data[63])}}, {32{$past(in_data[31])}}});

endmodule

bind pshift_unit pshift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_data   (in_data),
  .in_count  (in_count),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_pshift_unit.sv
`timescale 1ns/1ps
module sim_pshift_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [63:0] in_data = '0;
  logic [63:0] in_count = '0;
  logic        out_valid;
  logic [63:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [63:0] exp_q [$];
  string       tag_q [$];
  logic [63:0] last_exp = '0;

  always #10 clk = ~clk;

  pshift_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_data(in_data), .in_count(in_count),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] ref_shift(logic [2:0] op, logic [63:0] d, logic [63:0] c);
    int w; bit lft; bit ar;
    logic [63:0] r;
    r = '0;
    case (op)
      3'd0: begin w = 16; lft = 1; ar = 0; end
      3'd1: begin w = 32; lft = 1; ar = 0; end
      3'd2: begin w = 64; lft = 1; ar = 0; end
      3'd3: begin w = 16; lft = 0; ar = 0; end
      3'd4: begin w = 32; lft = 0; ar = 0; end
      3'd5: begin w = 64; lft = 0; ar = 0; end
      3'd6: begin w = 16; lft = 0; ar = 1; end
      default: begin w = 32; lft = 0; ar = 1; end
    endcase
    for (int b = 0; b < 64; b += w) begin
      for (int i = 0; i < w; i++) begin
        int src;
        if (c >= 64'(w)) src = -1;
        else src = lft ? i - int'(c[6:0]) : i + int'(c[6:0]);
        if (src >= 0 && src < w) r[b+i] = d[b+src];
        else r[b+i] = ar ? d[b+w-1] : 1'b0;
      end
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [2:0] op, logic [63:0] d, logic [63:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d; in_count = c;
    exp_q.push_back(ref_shift(op, d, c));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op = 3'(i); in_data = {$urandom, $urandom}; in_count = 64'(i);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected valid", 64'(out_valid), 64'd0);
      end else begin
        string t;
        logic [63:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        check(t, out_data, e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    rst = 1'b0;

    // R1 logical left
    send("R1 sll16", 3'd0, 64'h8001_4002_1234_FFFF, 64'd1);
    send("R1 sll32", 3'd1, 64'h8765_4321_F00D_BEEF, 64'd4);
    send("R1 sll64", 3'd2, 64'h0000_0000_0000_0003, 64'd63);
    // R2 logical right
    send("R2 srl16", 3'd3, 64'h8001_4002_1234_FFFF, 64'd3);
    send("R2 srl32", 3'd4, 64'hFFFF_FFFF_8000_0001, 64'd31);
    send("R2 srl64", 3'd5, 64'hF000_0000_0000_0000, 64'd60);
    // R3 arithmetic right
    send("R3 sra16", 3'd6, 64'h8000_7FFF_C3A5_0F0F, 64'd3);
    send("R3 sra32", 3'd7, 64'h8000_0000_7FFF_FFFF, 64'd31);
    // R4 lane isolation
    send("R4 sll16 edge", 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8);
    send("R4 srl16 edge", 3'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd8);
    send("R4 sll32 edge", 3'd1, 64'h8000_0001_8000_0001, 64'd1);
    send("R4 sra32 edge", 3'd7, 64'h0000_0001_8000_0000, 64'd4);
    // R5 logical overrange
    send("R5 sll16 w", 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd16);
    send("R5 srl32 hi", 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000);
    send("R5 sll64 64", 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd64);
    send("R5 srl64 max", 3'd5, 64'hFFFF_FFFF_FFFF_FFFF, '1);
    // R6 arithmetic overrange
    send("R6 sra16 big", 3'd6, 64'h8000_7FFF_FFFF_0001, 64'd100);
    send("R6 sra32 hi", 3'd7, 64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0000);
    // R7 zero count on every code
    for (int op = 0; op < 8; op++)
      send("R7 zero count", 3'(op), 64'hA5C3_0F81_7E24_9BD6, 64'd0);
    // R8 single item then idle
    send("R8 single", 3'd4, 64'h1234_5678_9ABC_DEF0, 64'd8);
    @(negedge clk); in_valid = 1'b0;
    check("R8 valid after strobe", 64'(out_valid), 64'd1);
    @(negedge clk);
    check("R8 valid drops", 64'(out_valid), 64'd0);
    // R9 hold while idle
    idle(4);
    check("R9 hold", out_data, last_exp);
    // random mix
    for (int n = 0; n < 300; n++)
      send("R4 random", 3'($urandom_range(0, 7)), {$urandom, $urandom},
           64'($urandom_range(0, 70)));
    idle(3);
    // R10 reset with strobe
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R10 reset with strobe", 64'(out_valid), 64'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R10 after reset", 64'(out_valid), 64'd0);
    check("R8 queue drained", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule